// File: doc/BRIEF.md
# Virtualized Identity Register Access Unit

This block holds the identity value that a guest operating system sees in place of the processor's real identity. It decides what happens to every system-register request aimed either at this virtual identity register or at the physical identity register. A request carries the privilege level of the requester, the state of the hypervisor level (implemented, enabled, running 64-bit), the two nested-virtualization control bits, the trap-general bit, an ID-trap feature flag, a register select, a read/write flag and write data.

One cycle after each valid request the block returns exactly one outcome. The outcome is read data, a completed write, a redirection to a memory offset, a trap with a target level and a syndrome class, or an undefined-instruction result. The physical identity value and the reset value of the virtual register are parameters. The surrounding pipeline carries out the memory access or the exception entry that an outcome calls for.

Top module: `vid_access_unit`

## Requirements
- R1: After reset `rsp_valid` is 0 and `rsp_kind` is 0. A first read of the virtual register at level 2 returns `VIRT_RESET` zero-extended to 64 bits.
- R2: Each request with `req_valid`=1 gives `rsp_valid`=1 on the next cycle with exactly one bit of `rsp_kind` set. The bits are 0 data, 1 write done, 2 redirect, 3 trap, 4 undefined. Fields that do not belong to the outcome read zero. With no request, `rsp_valid` and `rsp_kind` are 0.
- R3: `req_sel`=0 selects the virtual register and `req_sel`=1 selects the physical register. Any access to the virtual register from level 0 is undefined and leaves the register unchanged.
- R4: At level 1, when the hypervisor level is enabled and both `nv` and `nv2` are 1, a virtual-register access is redirected with `rsp_offset`=0x088. The register is unchanged.
- R5: At level 1, when the hypervisor level is enabled with `nv`=1 and `nv2`=0, the access traps to level 2 with class 0x18. Every other level-1 case is undefined. `el2_en` counts only when `el2_impl` is 1.
- R6: At level 2 the virtual register is read and written directly. Bits 63:32 always read as zero, and the write data in those bits is discarded.
- R7: At level 3 with the hypervisor level implemented, access is direct. Without it, a read returns `PHYS_ID`, and a write reports write done but leaves the register unchanged.
- R8: A physical-register read at level 1 returns the virtual register when the hypervisor level is enabled and 64-bit. Otherwise it returns `PHYS_ID`. At levels 2 and 3 it always returns `PHYS_ID`.
- R9: A physical-register read at level 0 is undefined when `idst_feat`=0. With the feature present it traps with class 0x18 to level 2 when the hypervisor level is enabled, 64-bit and `tge`=1, and to level 1 otherwise.
- R10: A write to the physical register is undefined at every level and leaves the virtual register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_wr | input | 1 | 1 write, 0 read |
| req_sel | input | 1 | 0 virtual register, 1 physical register |
| req_el | input | 2 | Requester privilege level 0..3 |
| el2_impl | input | 1 | Hypervisor level implemented |
| el2_en | input | 1 | Hypervisor level enabled in current security state |
| el2_is64 | input | 1 | Hypervisor level runs in 64-bit state |
| nv | input | 1 | Nested-virtualization enable bit |
| nv2 | input | 1 | Nested-virtualization memory-redirect bit |
| tge | input | 1 | Trap-general bit |
| idst_feat | input | 1 | ID-trap feature present |
| wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 5 | One-hot outcome |
| rsp_data | output | 64 | Read data |
| rsp_target_el | output | 2 | Trap target level |
| rsp_class | output | 6 | Trap syndrome class |
| rsp_offset | output | 12 | Redirect byte offset |

## Verification
The virtual register is tried at every privilege level with each setting of the nested bits. Enabled and disabled hypervisor states are mixed in, including enable without implementation. This separates redirect, trap, undefined and direct outcomes, and each is followed by a level-2 read-back that shows whether the register changed. The physical register is read under every combination that flips the virtual substitution and the trap target, so swapped conditions show up as wrong data or a wrong level. A write with nonzero upper bits separates the 32 stored bits from the discarded ones.

// File: rtl/vid_access_unit.sv
module vid_access_unit #(
  parameter logic [63:0] PHYS_ID     = 64'h0000_0000_410F_D034,
  parameter logic [31:0] VIRT_RESET  = 32'h0000_0000,
  parameter logic [11:0] NEST_OFFSET = 12'h088,
  parameter logic [5:0]  TRAP_CLASS  = 6'h18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_wr,
  input  logic        req_sel,
  input  logic [1:0]  req_el,
  input  logic        el2_impl,
  input  logic        el2_en,
  input  logic        el2_is64,
  input  logic        nv,
  input  logic        nv2,
  input  logic        tge,
  input  logic        idst_feat,
  input  logic [63:0] wdata,
  output logic        rsp_valid,
  output logic [4:0]  rsp_kind,
  output logic [63:0] rsp_data,
  output logic [1:0]  rsp_target_el,
  output logic [5:0]  rsp_class,
  output logic [11:0] rsp_offset
);
  localparam logic [4:0]  K_DATA  = 5'b00001;
  localparam logic [4:0]  K_WDONE = 5'b00010;
  localparam logic [4:0]  K_REDIR = 5'b00100;
  localparam logic [4:0]  K_TRAP  = 5'b01000;
  localparam logic [4:0]  K_UNDEF = 5'b10000;
  localparam logic [63:0] LOW_MASK = 64'h0000_0000_FFFF_FFFF;

  logic [63:0] vreg;
  logic        hyp_on;
  logic [4:0]  k_n;
  logic [63:0] d_n;
  logic [1:0]  t_n;
  logic [5:0]  c_n;
  logic [11:0] o_n;
  logic        we;

  assign hyp_on = el2_impl & el2_en;

  always_comb begin
    k_n = K_UNDEF;
    d_n = '0;
    t_n = '0;
    c_n = '0;
    o_n = '0;
    we  = 1'b0;
    if (!req_sel) begin
      case (req_el)
        2'd1: begin
          if (hyp_on && nv && nv2) begin
            k_n = K_REDIR;
            o_n = NEST_OFFSET;
          end else if (hyp_on && nv) begin
            k_n = K_TRAP;
            t_n = 2'd2;
            c_n = TRAP_CLASS;
          end
        end
        2'd2, 2'd3: begin
          if (req_el == 2'd3 && !el2_impl) begin
            if (req_wr) k_n = K_WDONE;
            else begin
              k_n = K_DATA;
              d_n = PHYS_ID;
            end
          end else if (req_wr) begin
            k_n = K_WDONE;
            we  = 1'b1;
          end else begin
            k_n = K_DATA;
            d_n = vreg;
          end
        end
        default: k_n = K_UNDEF;
      endcase
    end else if (!req_wr) begin
      case (req_el)
        2'd0: begin
          if (idst_feat) begin
            k_n = K_TRAP;
            c_n = TRAP_CLASS;
            t_n = (hyp_on && el2_is64 && tge) ? 2'd2 : 2'd1;
          end
        end
        2'd1: begin
          k_n = K_DATA;
          d_n = (hyp_on && el2_is64) ? vreg : PHYS_ID;
        end
        default: begin
          k_n = K_DATA;
          d_n = PHYS_ID;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vreg          <= {32'b0, VIRT_RESET};
      rsp_valid     <= 1'b0;
      rsp_kind      <= '0;
      rsp_data      <= '0;
      rsp_target_el <= '0;
      rsp_class     <= '0;
      rsp_offset    <= '0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_kind      <= req_valid ? k_n : '0;
      rsp_data      <= req_valid ? d_n : '0;
      rsp_target_el <= req_valid ? t_n : '0;
      rsp_class     <= req_valid ? c_n : '0;
      rsp_offset    <= req_valid ? o_n : '0;
      if (req_valid && we) vreg <= wdata & LOW_MASK;
    end
  end
endmodule

// File: rtl/vid_access_unit_chk.sv
module vid_access_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_wr,
  input logic        req_sel,
  input logic [1:0]  req_el,
  input logic        rsp_valid,
  input logic [4:0]  rsp_kind,
  input logic [63:0] rsp_data,
  input logic [1:0]  rsp_target_el,
  input logic [63:0] vreg
);
  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(rsp_kind) == 1);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> rsp_kind == 5'b0);
  a_r3_el0_virtual_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_sel && req_el == 2'd0) |=> rsp_kind == 5'b10000);
  a_r3_el0_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_el == 2'd0) |=> $stable(vreg));
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_sel && !req_wr && req_el == 2'd2) |=> rsp_data[63:32] == 32'b0);
  a_r6_reg_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    vreg[63:32] == 32'b0);
  a_r10_phys_write_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sel && req_wr) |=> (rsp_kind == 5'b10000 && $stable(vreg)));
  a_r9_trap_target: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind[3]) |-> (rsp_target_el == 2'd1 || rsp_target_el == 2'd2));
endmodule

bind vid_access_unit vid_access_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
  .req_sel(req_sel), .req_el(req_el), .rsp_valid(rsp_valid),
  .rsp_kind(rsp_kind), .rsp_data(rsp_data), .rsp_target_el(rsp_target_el),
  .vreg(vreg)
);

// File: tb/sim_vid_access_unit.sv
module sim_vid_access_unit;
  localparam time CLK_P = 10ns;
  localparam logic [63:0] P_ID  = 64'h0000_0000_51C2_E4B7;
  localparam logic [31:0] V_RST = 32'h4E30_1A25;
  localparam logic [4:0] KD = 5'b00001, KW = 5'b00010, KR = 5'b00100, KT = 5'b01000, KU = 5'b10000;
  // flag order: impl en is64 nv nv2 tge feat
  localparam logic [6:0] F_ON64   = 7'b1110000;
  localparam logic [6:0] F_NEST   = 7'b1101100;
  localparam logic [6:0] F_NVONLY = 7'b1101000;
  localparam logic [6:0] F_NV2    = 7'b1100100;
  localparam logic [6:0] F_OFFNV  = 7'b1001100;
  localparam logic [6:0] F_NOIMP  = 7'b0111100;
  localparam logic [6:0] F_ON32   = 7'b1100000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_wr = 0, req_sel = 0;
  logic [1:0] req_el = 0;
  logic el2_impl = 0, el2_en = 0, el2_is64 = 0, nv = 0, nv2 = 0, tge = 0, idst_feat = 0;
  logic [63:0] wdata = 0;
  logic rsp_valid;
  logic [4:0] rsp_kind;
  logic [63:0] rsp_data;
  logic [1:0] rsp_target_el;
  logic [5:0] rsp_class;
  logic [11:0] rsp_offset;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  vid_access_unit #(.PHYS_ID(P_ID), .VIRT_RESET(V_RST)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .req_sel(req_sel), .req_el(req_el), .el2_impl(el2_impl), .el2_en(el2_en),
    .el2_is64(el2_is64), .nv(nv), .nv2(nv2), .tge(tge), .idst_feat(idst_feat),
    .wdata(wdata), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
    .rsp_target_el(rsp_target_el), .rsp_class(rsp_class), .rsp_offset(rsp_offset));

  task automatic check(input string req, input logic [4:0] k, input logic [63:0] d,
                       input logic [1:0] t, input logic [5:0] c, input logic [11:0] o);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_kind !== k || rsp_data !== d || rsp_target_el !== t ||
        rsp_class !== c || rsp_offset !== o) begin
      errors++;
      $display("FAIL %s: got v=%b k=%b d=%h t=%0d c=%h o=%h exp v=1 k=%b d=%h t=%0d c=%h o=%h",
               req, rsp_valid, rsp_kind, rsp_data, rsp_target_el, rsp_class, rsp_offset,
               k, d, t, c, o);
    end
  endtask

  task automatic access(input logic [1:0] el, input logic wr, input logic sel,
                        input logic [6:0] f, input logic [63:0] wd);
    @(negedge clk);
    req_el = el; req_wr = wr; req_sel = sel; wdata = wd;
    {el2_impl, el2_en, el2_is64, nv, nv2, tge, idst_feat} = f;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle_check;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_kind !== 5'b0) begin
      errors++;
      $display("FAIL R2 idle: got v=%b k=%b exp v=0 k=00000", rsp_valid, rsp_kind);
    end
  endtask

  task automatic readback(input string req, input logic [63:0] exp);
    access(2'd2, 0, 0, F_ON64, 64'h0);
    check(req, KD, exp, 2'd0, 6'h0, 12'h0);
  endtask

  task automatic t_reset;
    checks++;
    if (rsp_valid !== 1'b0 || rsp_kind !== 5'b0) begin
      errors++;
      $display("FAIL R1 reset: got v=%b k=%b exp v=0 k=00000", rsp_valid, rsp_kind);
    end
    readback("R1 reset value", {32'b0, V_RST});
    idle_check();
  endtask

  task automatic t_el0_virtual;
    access(2'd0, 0, 0, F_NEST, 64'h0);
    check("R3 el0 read", KU, 64'h0, 2'd0, 6'h0, 12'h0);
    access(2'd0, 1, 0, F_ON64, 64'h1111_2222);
    check("R3 el0 write", KU, 64'h0, 2'd0, 6'h0, 12'h0);
    readback("R3 el0 unchanged", {32'b0, V_RST});
  endtask

  task automatic t_el1_nested;
    access(2'd1, 1, 0, F_NEST, 64'hABCD_0000);
    check("R4 redirect write", KR, 64'h0, 2'd0, 6'h0, 12'h088);
    access(2'd1, 0, 0, F_NEST, 64'h0);
    check("R4 redirect read", KR, 64'h0, 2'd0, 6'h0, 12'h088);
    readback("R4 unchanged", {32'b0, V_RST});
  endtask

  task automatic t_el1_trap;
    access(2'd1, 1, 0, F_NVONLY, 64'h5555_5555);
    check("R5 nv trap", KT, 64'h0, 2'd2, 6'h18, 12'h0);
    access(2'd1, 0, 0, F_NV2, 64'h0);
    check("R5 nv2 only undef", KU, 64'h0, 2'd0, 6'h0, 12'h0);
    access(2'd1, 0, 0, F_OFFNV, 64'h0);
    check("R5 disabled undef", KU, 64'h0, 2'd0, 6'h0, 12'h0);
    access(2'd1, 1, 0, F_NOIMP, 64'h7777_7777);
    check("R5 not implemented undef", KU, 64'h0, 2'd0, 6'h0, 12'h0);
    readback("R5 unchanged", {32'b0, V_RST});
  endtask

  task automatic t_el2_rw;
    access(2'd2, 1, 0, F_ON64, 64'hDEAD_BEEF_0123_4567);
    check("R6 el2 write", KW, 64'h0, 2'd0, 6'h0, 12'h0);
    readback("R6 upper discarded", 64'h0000_0000_0123_4567);
  endtask

  task automatic t_el3;
    access(2'd3, 1, 0, F_ON64, 64'h0000_0000_89AB_CDEF);
    check("R7 el3 write", KW, 64'h0, 2'd0, 6'h0, 12'h0);
    access(2'd3, 0, 0, F_ON64, 64'h0);
    check("R7 el3 read", KD, 64'h0000_0000_89AB_CDEF, 2'd0, 6'h0, 12'h0);
    access(2'd3, 0, 0, F_NOIMP, 64'h0);
    check("R7 no-hyp read", KD, P_ID, 2'd0, 6'h0, 12'h0);
    access(2'd3, 1, 0, F_NOIMP, 64'h0000_0000_1357_9BDF);
    check("R7 no-hyp write", KW, 64'h0, 2'd0, 6'h0, 12'h0);
    readback("R7 no-hyp write ignored", 64'h0000_0000_89AB_CDEF);
  endtask

  task automatic t_phys_read;
    access(2'd1, 0, 1, F_ON64, 64'h0);
    check("R8 el1 substituted", KD, 64'h0000_0000_89AB_CDEF, 2'd0, 6'h0, 12'h0);
    access(2'd1, 0, 1, F_ON32, 64'h0);
    check("R8 el1 32-bit hyp", KD, P_ID, 2'd0, 6'h0, 12'h0);
    access(2'd1, 0, 1, F_OFFNV, 64'h0);
    check("R8 el1 disabled", KD, P_ID, 2'd0, 6'h0, 12'h0);
    access(2'd2, 0, 1, F_ON64, 64'h0);
    check("R8 el2", KD, P_ID, 2'd0, 6'h0, 12'h0);
    access(2'd3, 0, 1, F_ON64, 64'h0);
    check("R8 el3", KD, P_ID, 2'd0, 6'h0, 12'h0);
  endtask

  task automatic t_phys_el0;
    access(2'd0, 0, 1, 7'b1110010, 64'h0);
    check("R9 no feature", KU, 64'h0, 2'd0, 6'h0, 12'h0);
    access(2'd0, 0, 1, 7'b1110011, 64'h0);
    check("R9 trap el2", KT, 64'h0, 2'd2, 6'h18, 12'h0);
    access(2'd0, 0, 1, 7'b1110001, 64'h0);
    check("R9 tge clear", KT, 64'h0, 2'd1, 6'h18, 12'h0);
    access(2'd0, 0, 1, 7'b1100011, 64'h0);
    check("R9 32-bit hyp", KT, 64'h0, 2'd1, 6'h18, 12'h0);
  endtask

  task automatic t_phys_write;
    access(2'd2, 1, 1, F_ON64, 64'h0000_0000_2468_ACE0);
    check("R10 el2 phys write", KU, 64'h0, 2'd0, 6'h0, 12'h0);
    access(2'd3, 1, 1, F_ON64, 64'h0000_0000_2468_ACE0);
    check("R10 el3 phys write", KU, 64'h0, 2'd0, 6'h0, 12'h0);
    readback("R10 unchanged", 64'h0000_0000_89AB_CDEF);
    idle_check();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_el0_virtual();
    t_el1_nested();
    t_el1_trap();
    t_el2_rw();
    t_el3();
    t_phys_read();
    t_phys_el0();
    t_phys_write();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule